// File: doc/BRIEF.md
# TDM Control and Signalling Channel Port

This block sits on an 8 kHz time-division serial stream and owns the first two timeslots of each frame. Timeslot 1 carries a full control byte in each direction. Timeslot 0 carries a slow signalling channel, which packs one or two bits per frame into an otherwise empty slot. On the transmit side, each slot can be driven or left floating (output-enable low) under its own enable bit. On the receive side, both slots are captured on every frame in stream mode, whatever the enables are. When a receive byte is complete, a flag rises; reading that byte clears the flag.

Everything runs on the bit clock. A frame pulse marks bit 0 of timeslot 0, and bits travel MSB first, eight bit clocks per slot. A small register port selects the setting, the transmit bytes and the received bytes. A serial-interface mode bit switches off all slot insertion and capture. Reset leaves the block in that mode.

Top module: `tdm_chan_port`

## Requirements
- R1: After reset, the control register (address 0) reads 8'h02, both receive flags are low and `sdo_oe` is low. Control layout: bit 7 = control-slot enable, bit 6 = signalling-slot enable, bit 5 = slow signalling rate (1 bit per frame), bit 1 = serial-interface mode.
- R2: With the control-slot enable set in stream mode, timeslot 1 (bit times 8..15 after the frame pulse) drives the byte held in address 1 at the start of the frame, MSB first, with `sdo_oe` high.
- R3: With the control-slot enable clear, `sdo_oe` is low for all of timeslot 1.
- R4: In stream mode, the byte received in timeslot 1 is stored into the address-1 read register at the end of the slot, and `rx_c_new` rises, whatever the control-slot enable is.
- R5: At the fast rate (bit 5 clear), timeslot 0 bit times 0 and 1 carry the next two bits of the signalling transmit byte, MSB first. The byte reloads from address 2 after 4 frames. `sdo_oe` is high for the whole slot while the signalling enable is set.
- R6: At the slow rate (bit 5 set), only bit time 0 carries a signalling bit, and the byte reloads after 8 frames.
- R7: While timeslot 0 is driven, every bit time that carries no signalling bit is driven as 1.
- R8: With the signalling enable clear, `sdo_oe` is low for all of timeslot 0, and the transmit byte does not advance.
- R9: In stream mode, the signalling bits received in timeslot 0 (one or two per frame, per the rate bit) are assembled MSB first into the address-2 read register, and `rx_d_new` rises when eight bits have been collected, whatever the signalling enable is.
- R10: In serial-interface mode (bit 1 set), `sdo_oe` stays low and neither receive register nor flag changes.
- R11: Reading address 1 clears `rx_c_new`, and reading address 2 clears `rx_d_new`. A capture in the same cycle keeps the flag set.
- R12: Timeslots 2 and above are never driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp | input | 1 | Frame pulse, high during bit 0 of timeslot 0 |
| sdi | input | 1 | Serial receive data |
| sdo | output | 1 | Serial transmit data |
| sdo_oe | output | 1 | Transmit output enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears flags) |
| addr | input | 2 | Register address: 0 control, 1 control slot byte, 2 signalling byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (received bytes at addresses 1 and 2) |
| rx_c_new | output | 1 | New control slot byte received |
| rx_d_new | output | 1 | New signalling byte received |

## Verification
The hardest state to reach is a signalling transmit pointer left on an odd bit. This happens when the rate bit switches from slow to fast partway through a byte, so that the second bit time of the slot has to fall back to the fill value and the reload happens early. The random phase rewrites the control register at arbitrary frames with random rate and enable bits, which brings this state about repeatedly. The bench model tracks the pointer and the receive bit count bit by bit, so every odd alignment is checked. Directed frames with both enables clear, and frames in serial-interface mode, show that capture follows the mode alone.

// File: rtl/tdm_chan_pkg.sv
package tdm_chan_pkg;

    localparam int SLOT_BITS = 8;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CSLOT = 2'd1;
    localparam logic [1:0] ADDR_DSLOT = 2'd2;

    typedef struct packed {
        logic       c_en;      // bit 7
        logic       d_en;      // bit 6
        logic       d_slow;    // bit 5
        logic [2:0] spare_hi;  // bits 4..2
        logic       ssi;       // bit 1
        logic       spare_lo;  // bit 0
    } ctrl_t;

    localparam logic [7:0] CTRL_RESET = 8'h02;

endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
    parameter int FRAME_BITS = 32,
    parameter int POS_W      = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fp,
    output logic [POS_W-1:0] pos,
    output logic             synced
);

    typedef struct packed {
        logic [POS_W-1:0] cnt;
        logic             sync;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        pos  = fp ? '0 : st_q.cnt;
        if (pos == POS_W'(FRAME_BITS - 1)) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = pos + 1'b1;
        end
        st_d.sync = st_q.sync | fp;
        synced    = st_d.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tdm_dch_tx.sv
module tdm_dch_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_slot0,
    input  logic [2:0] k,
    input  logic       slow,
    input  logic       d_en,
    input  logic [7:0] tx_byte,
    output logic       bit_o
);

    typedef struct packed {
        logic [7:0] sbuf;
        logic [3:0] ptr;
    } st_t;

    st_t        st_d, st_q;
    logic [3:0] nb;
    logic [3:0] idx;
    logic [3:0] nptr;
    logic       carrying;

    always_comb begin
        st_d     = st_q;
        nb       = slow ? 4'd1 : 4'd2;
        idx      = st_q.ptr + {1'b0, k};
        carrying = ({1'b0, k} < nb);
        nptr     = st_q.ptr + nb;
        bit_o    = 1'b1;
        if (in_slot0 && carrying && (idx < 4'd8)) begin
            bit_o = st_q.sbuf[3'd7 - idx[2:0]];
        end
        if (in_slot0 && d_en && (k == 3'd7)) begin
            if (nptr >= 4'd8) begin
                st_d.sbuf = tx_byte;
                st_d.ptr  = '0;
            end else begin
                st_d.ptr  = nptr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tdm_rx_capture.sv
module tdm_rx_capture (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_slot0,
    input  logic       in_slot1,
    input  logic [2:0] k,
    input  logic       slow,
    input  logic       sdi,
    input  logic       clr_c,
    input  logic       clr_d,
    output logic [7:0] c_byte,
    output logic [7:0] d_byte,
    output logic       c_new,
    output logic       d_new
);

    typedef struct packed {
        logic [6:0] c_sh;
        logic [6:0] d_acc;
        logic [2:0] d_cnt;
        logic [7:0] c_byte;
        logic [7:0] d_byte;
        logic       c_new;
        logic       d_new;
    } st_t;

    st_t        st_d, st_q;
    logic [3:0] nb;

    always_comb begin
        st_d = st_q;
        nb   = slow ? 4'd1 : 4'd2;
        if (clr_c) st_d.c_new = 1'b0;
        if (clr_d) st_d.d_new = 1'b0;
        if (in_slot1) begin
            if (k == 3'd7) begin
                st_d.c_byte = {st_q.c_sh, sdi};
                st_d.c_new  = 1'b1;
            end else begin
                st_d.c_sh = {st_q.c_sh[5:0], sdi};
            end
        end
        if (in_slot0 && ({1'b0, k} < nb)) begin
            if (st_q.d_cnt == 3'd7) begin
                st_d.d_byte = {st_q.d_acc, sdi};
                st_d.d_new  = 1'b1;
                st_d.d_cnt  = '0;
            end else begin
                st_d.d_acc = {st_q.d_acc[5:0], sdi};
                st_d.d_cnt = st_q.d_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign c_byte = st_q.c_byte;
    assign d_byte = st_q.d_byte;
    assign c_new  = st_q.c_new;
    assign d_new  = st_q.d_new;

endmodule

// File: rtl/tdm_chan_port.sv
module tdm_chan_port
    import tdm_chan_pkg::*;
#(
    parameter int FRAME_SLOTS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fp,
    input  logic       sdi,
    output logic       sdo,
    output logic       sdo_oe,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       rx_c_new,
    output logic       rx_d_new
);

    localparam int FRAME_BITS = FRAME_SLOTS * SLOT_BITS;
    localparam int POS_W      = $clog2(FRAME_BITS);

    typedef struct packed {
        ctrl_t      ctrl;
        logic [7:0] c_tx;
        logic [7:0] d_tx;
        logic [7:0] c_out;
    } st_t;

    st_t              st_d, st_q;
    ctrl_t            ctrl_q;
    logic [POS_W-1:0] pos_w;
    logic             synced;
    logic             active;
    logic             in_slot0;
    logic             in_slot1;
    logic [2:0]       k;
    logic             d_bit;
    logic             clr_c;
    logic             clr_d;
    logic [7:0]       c_rx;
    logic [7:0]       d_rx;

    assign ctrl_q = st_q.ctrl;

    tdm_frame_timer #(
        .FRAME_BITS(FRAME_BITS),
        .POS_W     (POS_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .fp    (fp),
        .pos   (pos_w),
        .synced(synced)
    );

    always_comb begin
        active   = synced && !st_q.ctrl.ssi;
        in_slot0 = active && (pos_w < POS_W'(SLOT_BITS));
        in_slot1 = active && (pos_w >= POS_W'(SLOT_BITS))
                          && (pos_w < POS_W'(2 * SLOT_BITS));
        k        = pos_w[2:0];
        clr_c    = rd_en && (addr == ADDR_CSLOT);
        clr_d    = rd_en && (addr == ADDR_DSLOT);
    end

    tdm_dch_tx u_dtx (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_slot0(in_slot0),
        .k       (k),
        .slow    (st_q.ctrl.d_slow),
        .d_en    (st_q.ctrl.d_en),
        .tx_byte (st_q.d_tx),
        .bit_o   (d_bit)
    );

    tdm_rx_capture u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_slot0(in_slot0),
        .in_slot1(in_slot1),
        .k       (k),
        .slow    (st_q.ctrl.d_slow),
        .sdi     (sdi),
        .clr_c   (clr_c),
        .clr_d   (clr_d),
        .c_byte  (c_rx),
        .d_byte  (d_rx),
        .c_new   (rx_c_new),
        .d_new   (rx_d_new)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (addr)
                ADDR_CTRL:  st_d.ctrl = ctrl_t'(wdata);
                ADDR_CSLOT: st_d.c_tx = wdata;
                ADDR_DSLOT: st_d.d_tx = wdata;
                default:    ;
            endcase
        end
        // control byte is frozen at the end of slot 0 so a write never tears it
        if (synced && (pos_w == POS_W'(SLOT_BITS - 1))) begin
            st_d.c_out = st_q.c_tx;
        end

        sdo    = 1'b1;
        sdo_oe = 1'b0;
        if (in_slot0) begin
            sdo    = d_bit;
            sdo_oe = st_q.ctrl.d_en;
        end else if (in_slot1) begin
            sdo    = st_q.c_out[3'd7 - k];
            sdo_oe = st_q.ctrl.c_en;
        end

        unique case (addr)
            ADDR_CTRL:  rdata = st_q.ctrl;
            ADDR_CSLOT: rdata = c_rx;
            ADDR_DSLOT: rdata = d_rx;
            default:    rdata = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl  <= ctrl_t'(CTRL_RESET);
            st_q.c_tx  <= '0;
            st_q.d_tx  <= '0;
            st_q.c_out <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tdm_chan_port_chk.sv
module tdm_chan_port_chk #(
    parameter int POS_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sdo,
    input logic             sdo_oe,
    input logic             rx_c_new,
    input logic             rx_d_new,
    input logic             rd_en,
    input logic [1:0]       addr,
    input logic [POS_W-1:0] pos,
    input logic             ssi
);

    AST_SSI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ssi |-> !sdo_oe); // R10

    AST_HIGH_SLOTS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pos >= POS_W'(16)) |-> !sdo_oe); // R12

    AST_FILL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && pos >= POS_W'(2) && pos < POS_W'(8)) |-> sdo); // R7

    AST_C_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_c_new) |-> ($past(pos) == POS_W'(15))); // R4

    AST_D_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_d_new) |-> ($past(pos) < POS_W'(2))); // R9

    AST_C_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'd1 && pos != POS_W'(15)) |=> !rx_c_new); // R11

endmodule

bind tdm_chan_port tdm_chan_port_chk #(.POS_W(POS_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sdo     (sdo),
    .sdo_oe  (sdo_oe),
    .rx_c_new(rx_c_new),
    .rx_d_new(rx_d_new),
    .rd_en   (rd_en),
    .addr    (addr),
    .pos     (pos_w),
    .ssi     (ctrl_q.ssi)
);

// File: tb/tb_tdm_chan_port.sv
`timescale 1ns/1ps
module tb_tdm_chan_port;

    localparam int FB = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fp = 1'b0;
    logic       sdi = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic       sdo, sdo_oe, rx_c_new, rx_d_new;
    logic [7:0] rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] m_ctrl = 8'h02;
    logic [7:0] m_ctx = 8'h00;
    logic [7:0] m_dtx = 8'h00;
    logic [7:0] m_dbuf = 8'h00;
    int         m_dptr = 0;
    logic [7:0] m_crx = 8'h00;
    logic [7:0] m_drx = 8'h00;
    logic [7:0] m_dacc = 8'h00;
    int         m_dcnt = 0;
    bit         m_cnew = 1'b0;
    bit         m_dnew = 1'b0;

    always #2.5 clk = ~clk;

    tdm_chan_port #(.FRAME_SLOTS(4)) dut (
        .clk(clk), .rst_n(rst_n), .fp(fp), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .rx_c_new(rx_c_new), .rx_d_new(rx_d_new)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_dbit(int kk, int nb);
        int idx;
        if (kk < nb) begin
            idx = m_dptr + kk;
            if (idx < 8) return m_dbuf[7 - idx];
        end
        return 1'b1;
    endfunction

    // op: 0 none, 1 write, 2 read; access happens at bit time 20
    task automatic run_frame(int op, logic [1:0] a, logic [7:0] d);
        logic [7:0] rxc;
        logic [1:0] rxd;
        bit         act_m;
        int         nb;
        logic [7:0] c_out;
        bit         exp_oe;
        bit         exp_sdo;
        logic [7:0] exp_rd;
        string      req;
        rxc   = 8'($urandom);
        rxd   = 2'($urandom);
        act_m = !m_ctrl[1];
        nb    = m_ctrl[5] ? 1 : 2;
        c_out = m_ctx;
        for (int b = 0; b < FB; b++) begin
            @(negedge clk);
            fp = (b == 0);
            if (b < nb) sdi = rxd[b];
            else if (b >= 8 && b < 16) sdi = rxc[15 - b];
            else sdi = 1'($urandom);
            wr_en = (b == 20) && (op == 1);
            rd_en = (b == 20) && (op == 2);
            addr  = (b == 20) ? a : 2'd3;
            wdata = d;
            #1;
            if (b < 8) begin
                exp_oe = act_m && m_ctrl[6];
                req = m_ctrl[1] ? "R10" : (m_ctrl[6] ? "R5" : "R8");
            end else if (b < 16) begin
                exp_oe = act_m && m_ctrl[7];
                req = m_ctrl[1] ? "R10" : (m_ctrl[7] ? "R2" : "R3");
            end else begin
                exp_oe = 1'b0;
                req = "R12";
            end
            check(sdo_oe == exp_oe, req, $sformatf("oe bit %0d", b), sdo_oe, exp_oe);
            if (exp_oe) begin
                if (b < 8) begin
                    exp_sdo = exp_dbit(b, nb);
                    req = (b < nb) ? (nb == 1 ? "R6" : "R5") : "R7";
                end else begin
                    exp_sdo = c_out[15 - b];
                    req = "R2";
                end
                check(sdo == exp_sdo, req, $sformatf("sdo bit %0d", b), sdo, exp_sdo);
            end
            if (b == 7 && act_m) begin
                for (int j = 0; j < nb; j++) begin
                    m_dacc = {m_dacc[6:0], rxd[j]};
                    if (m_dcnt == 7) begin
                        m_drx = m_dacc; m_dnew = 1'b1; m_dcnt = 0;
                    end else m_dcnt++;
                end
                if (m_ctrl[6]) begin
                    if (m_dptr + nb >= 8) begin
                        m_dbuf = m_dtx; m_dptr = 0;
                    end else m_dptr = m_dptr + nb;
                end
            end
            if (b == 15 && act_m) begin
                m_crx = rxc; m_cnew = 1'b1;
            end
            if (b == 20 && op == 2) begin
                exp_rd = (a == 2'd0) ? m_ctrl : (a == 2'd1) ? m_crx : (a == 2'd2) ? m_drx : 8'h00;
                req = (a == 2'd1) ? "R4" : (a == 2'd2) ? "R9" : "R1";
                check(rdata == exp_rd, req, $sformatf("read addr %0d", a), rdata, exp_rd);
                if (a == 2'd1) m_cnew = 1'b0;
                if (a == 2'd2) m_dnew = 1'b0;
            end
            if (b == 20 && op == 1) begin
                if (a == 2'd0) m_ctrl = d;
                if (a == 2'd1) m_ctx = d;
                if (a == 2'd2) m_dtx = d;
            end
            if (b == FB - 1) begin
                check(rx_c_new == m_cnew, "R11", "rx_c_new", rx_c_new, m_cnew);
                check(rx_d_new == m_dnew, "R11", "rx_d_new", rx_d_new, m_dnew);
            end
        end
        wr_en = 1'b0;
        rd_en = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_en = 1'b1;
        addr  = 2'd0;
        #1;
        check(rdata == 8'h02, "R1", "ctrl reset", rdata, 8'h02);
        check(sdo_oe == 1'b0, "R1", "oe reset", sdo_oe, 0);
        check(rx_c_new == 1'b0 && rx_d_new == 1'b0, "R1", "flags reset",
              {rx_c_new, rx_d_new}, 0);
        @(negedge clk);
        rd_en = 1'b0;

        // serial-interface mode: nothing driven, nothing captured (R10)
        run_frame(0, 2'd0, 8'h00);
        run_frame(1, 2'd1, 8'hA5);
        run_frame(1, 2'd2, 8'h3C);
        run_frame(1, 2'd0, 8'hC0);
        // fast rate, both enables
        for (int i = 0; i < 10; i++) run_frame((i % 3 == 0) ? 2 : 0, (i % 2) ? 2'd1 : 2'd2, 8'h00);
        // both enables clear: capture continues (R4, R9)
        run_frame(1, 2'd0, 8'h00);
        for (int i = 0; i < 6; i++) run_frame(2, (i % 2) ? 2'd1 : 2'd2, 8'h00);
        // slow rate (R6)
        run_frame(1, 2'd2, 8'h96);
        run_frame(1, 2'd0, 8'hE0);
        for (int i = 0; i < 18; i++) run_frame((i % 4 == 3) ? 2 : 0, 2'd2, 8'h00);
        // random phase
        for (int i = 0; i < 90; i++) begin
            r = $urandom;
            unique case (r[2:0] % 7)
                0: run_frame(0, 2'd0, 8'h00);
                1: run_frame(1, 2'd0, {r[8], r[9], r[10], 3'b000, (r[13:11] == 3'd0), 1'b0});
                2: run_frame(1, 2'd1, r[23:16]);
                3: run_frame(1, 2'd2, r[31:24]);
                4: run_frame(2, 2'd1, 8'h00);
                5: run_frame(2, 2'd2, 8'h00);
                default: run_frame(2, 2'd0, 8'h00);
            endcase
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule